// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps one status byte for every transmitted frame that finished with an error or that asked for an interrupt. The transmit engine reports each finished frame as a one-cycle event with its error flags. The host reads the oldest byte at a byte-wide status port, and any host write to that port discards the byte. As long as any byte is held, the completion-pending output stays high, so a host service routine reads and pops until it drops.

The block also gates the transmitter. Any recorded error halts transmission until the host issues a transmit-enable pulse. An underrun or a jabber also raises a reset-required flag. While that flag is set, transmit-enable has no effect. Only a transmit-reset pulse clears the flag, and that pulse also flushes the queue. A frame completion that arrives while the queue is full is not stored. Instead it marks an overflow bit in the newest stored byte.

Top module: `txcmp_status_stack`

## Requirements
- R1: After reset, `stat_byte` is 0 and `cmp_pending`, `xmit_halted` and `xmit_reset_req` are low.
- R2: A completion event with at least one of maximum collisions, underrun, jabber or interrupt request stores the byte 0x80 | 0x08·maxcoll | 0x10·underrun | 0x20·jabber | 0x40·irq. The byte is visible on the cycle after the event if the queue was empty.
- R3: A completion event with none of those four flags stores nothing.
- R4: `stat_byte` shows the oldest stored byte, or 0 when nothing is stored.
- R5: A `host_pop` pulse removes the oldest byte. A pop of an empty queue has no effect.
- R6: `cmp_pending` is high exactly while at least one byte is stored.
- R7: The queue holds DEPTH (default 4) bytes. An event that would be stored while the queue is full and not popped is not stored. It sets bit 0x04 in the newest stored byte and leaves the other bytes unchanged.
- R8: A pop and a storing event in the same cycle on a full queue store the new byte normally, without an overflow mark.
- R9: An event with maxcoll, underrun or jabber sets `xmit_halted`. An `xmit_enable` pulse clears it when no reset is required. An interrupt-only event does not halt.
- R10: Underrun or jabber sets `xmit_reset_req`. While `xmit_reset_req` is set, `xmit_enable` leaves `xmit_halted` set.
- R11: An `xmit_reset` pulse empties the queue and clears `xmit_reset_req`. A completion event in the same cycle is ignored.
- R12: An error event in the same cycle as `xmit_enable` leaves `xmit_halted` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_valid | input | 1 | Frame completion event |
| done_maxcoll | input | 1 | Frame hit maximum collisions |
| done_underrun | input | 1 | Frame hit a data underrun |
| done_jabber | input | 1 | Frame hit jabber |
| done_irq_req | input | 1 | Frame asked for an interrupt |
| host_pop | input | 1 | Host write to the status port; pops the oldest byte |
| xmit_enable | input | 1 | Transmit-enable pulse |
| xmit_reset | input | 1 | Transmit-reset pulse |
| stat_byte | output | 8 | Oldest status byte, or 0 |
| cmp_pending | output | 1 | Completion pending; high while bytes are held |
| xmit_halted | output | 1 | Transmitter stopped by an error |
| xmit_reset_req | output | 1 | Transmitter needs a reset before it may be enabled |

## Verification
Every result is held in a register one edge from its stimulus. A byte pushed into an empty queue, a pop, a flush and a change of the halt or reset-required flags are therefore all visible one cycle after the input pulse. The bench drives each pulse on a falling edge and lets one rising edge pass. It applies the same event to its own expected-byte queue and flag model, and compares all four outputs on the next falling edge. It never samples on the edge where the outputs move. Overflow marking and the same-cycle cases (pop with push on a full queue, enable with an error, reset with an event) are each set up so that their effect is observed on that next falling edge.

// File: rtl/txcmp_pkg.sv
package txcmp_pkg;
   localparam int STAT_W = 8;
   typedef logic [STAT_W-1:0] stat_t;

   localparam stat_t ST_OVF     = 8'h04;
   localparam stat_t ST_MAXCOLL = 8'h08;
   localparam stat_t ST_UNDER   = 8'h10;
   localparam stat_t ST_JABBER  = 8'h20;
   localparam stat_t ST_IRQ     = 8'h40;
   localparam stat_t ST_DONE    = 8'h80;

   function automatic stat_t make_stat(input logic mc, input logic un,
                                       input logic jb, input logic ir);
      stat_t s;
      s = ST_DONE;
      if (mc) s = s | ST_MAXCOLL;
      if (un) s = s | ST_UNDER;
      if (jb) s = s | ST_JABBER;
      if (ir) s = s | ST_IRQ;
      return s;
   endfunction
endpackage

// File: rtl/txcmp_queue.sv
module txcmp_queue
   import txcmp_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  flush,
   input  logic  push,
   input  stat_t din,
   input  logic  pop,
   output stat_t dout,
   output logic  nonempty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("txcmp_queue: DEPTH must lie in 2..256");
   end

   logic [PW-1:0] rd_ptr, wr_ptr, newest;
   logic [CW-1:0] cnt;
   stat_t         ent [DEPTH];
   logic          empty, full, do_pop, do_push, do_ovf;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == LAST_PTR) ? '0 : p + 1'b1;
   endfunction

   always_comb begin
      empty   = (cnt == '0);
      full    = (cnt == FULL_CNT);
      do_pop  = pop && !empty && !flush;
      do_push = push && !flush && (!full || do_pop);
      do_ovf  = push && !flush && full && !do_pop;
      newest  = (wr_ptr == '0) ? LAST_PTR : wr_ptr - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= bump(wr_ptr);
         if (do_pop)  rd_ptr <= bump(rd_ptr);
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      stat_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (do_push && wr_ptr == PW'(i))     q <= din;
         else if (do_ovf && newest == PW'(i))      q <= q | ST_OVF;
      end
      assign ent[i] = q;
   end

   assign dout     = empty ? '0 : ent[rd_ptr];
   assign nonempty = !empty;

   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL_CNT);
   a_r7_ovf_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (cnt == FULL_CNT));
   a_r5_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> (cnt == '0));
   a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0));
endmodule

// File: rtl/txcmp_gate.sv
module txcmp_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic err_evt,
   input  logic fatal_evt,
   input  logic enable_pulse,
   input  logic reset_pulse,
   output logic halted,
   output logic reset_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            reset_req <= 1'b0;
      else if (reset_pulse)  reset_req <= 1'b0;
      else if (fatal_evt)    reset_req <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           halted <= 1'b0;
      else if (err_evt)                     halted <= 1'b1;
      else if (enable_pulse && !reset_req)  halted <= 1'b0;
   end

   a_r10_req_implies_halt: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> halted);
   a_r9_err_sets_halt: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt |=> halted);
   a_r10_enable_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_req && !err_evt) |=> halted);
endmodule

// File: rtl/txcmp_status_stack.sv
module txcmp_status_stack
   import txcmp_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done_valid,
   input  logic       done_maxcoll,
   input  logic       done_underrun,
   input  logic       done_jabber,
   input  logic       done_irq_req,
   input  logic       host_pop,
   input  logic       xmit_enable,
   input  logic       xmit_reset,
   output logic [7:0] stat_byte,
   output logic       cmp_pending,
   output logic       xmit_halted,
   output logic       xmit_reset_req
);
   logic  accept, any_err, fatal, record;
   stat_t new_stat, top_stat;

   always_comb begin
      accept   = done_valid && !xmit_reset;
      any_err  = accept && (done_maxcoll || done_underrun || done_jabber);
      fatal    = accept && (done_underrun || done_jabber);
      record   = any_err || (accept && done_irq_req);
      new_stat = make_stat(done_maxcoll, done_underrun, done_jabber, done_irq_req);
   end

   txcmp_queue #(.DEPTH(DEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (xmit_reset),
      .push     (record),
      .din      (new_stat),
      .pop      (host_pop),
      .dout     (top_stat),
      .nonempty (cmp_pending)
   );

   txcmp_gate u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .err_evt      (any_err),
      .fatal_evt    (fatal),
      .enable_pulse (xmit_enable),
      .reset_pulse  (xmit_reset),
      .halted       (xmit_halted),
      .reset_req    (xmit_reset_req)
   );

   assign stat_byte = top_stat;

   a_r6_pending_has_done: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_pending |-> stat_byte[7]);
   a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_pending |-> (stat_byte == 8'h00));
   a_r3_noflag_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_maxcoll && !done_underrun && !done_jabber && !done_irq_req
       && !host_pop && !xmit_reset && !cmp_pending) |=> !cmp_pending);
   a_r11_reset_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
      xmit_reset |=> (!xmit_reset_req && !cmp_pending));
endmodule

// File: tb/txcmp_status_stack_bench.sv
module txcmp_status_stack_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dv = 0, mc = 0, un = 0, jb = 0, ir = 0, pop = 0, en = 0, rs = 0;
   logic [7:0] sb;
   logic       pend, halt, rreq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [7:0] exp_q[$];
   bit m_halt = 0, m_rreq = 0;

   always #5 clk = ~clk;

   txcmp_status_stack u_txcmp_status_stack (
      .clk(clk), .rst_n(rst_n), .done_valid(dv), .done_maxcoll(mc),
      .done_underrun(un), .done_jabber(jb), .done_irq_req(ir),
      .host_pop(pop), .xmit_enable(en), .xmit_reset(rs),
      .stat_byte(sb), .cmp_pending(pend), .xmit_halted(halt),
      .xmit_reset_req(rreq));

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: compares design outputs against the front of the expected queue
   task automatic check_all(input string tag);
      cmp(tag, "stat_byte", int'(sb), exp_q.size() > 0 ? int'(exp_q[0]) : 0);
      cmp(tag, "pending", int'(pend), int'(exp_q.size() > 0));
      cmp(tag, "halted", int'(halt), int'(m_halt));
      cmp(tag, "reset_req", int'(rreq), int'(m_rreq));
   endtask

   // driver: applies one cycle of stimulus and pushes the expected effect into the model
   task automatic step(input bit v, input bit a, input bit b, input bit c, input bit d,
                       input bit p, input bit e, input bit r, input string tag);
      logic [7:0] byt;
      bit old_rreq;
      dv = v; mc = a; un = b; jb = c; ir = d; pop = p; en = e; rs = r;
      @(posedge clk);
      old_rreq = m_rreq;
      if (r) begin
         exp_q.delete();
         m_rreq = 0;
         if (e && !old_rreq) m_halt = 0;
      end else begin
         if (p && exp_q.size() > 0) void'(exp_q.pop_front());
         if (v && (a || b || c || d)) begin
            byt = 8'h80 | (a ? 8'h08 : 8'h0) | (b ? 8'h10 : 8'h0)
                        | (c ? 8'h20 : 8'h0) | (d ? 8'h40 : 8'h0);
            if (exp_q.size() < 4) exp_q.push_back(byt);
            else exp_q[exp_q.size()-1] = exp_q[exp_q.size()-1] | 8'h04;
         end
         if (v && (a || b || c)) m_halt = 1;
         else if (e && !old_rreq) m_halt = 0;
         if (v && (b || c)) m_rreq = 1;
      end
      @(negedge clk);
      dv = 0; mc = 0; un = 0; jb = 0; ir = 0; pop = 0; en = 0; rs = 0;
      check_all(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");
      step(1,0,0,0,0, 0,0,0, "R3");            // no flags: nothing stored
      step(1,0,0,0,1, 0,0,0, "R2");            // irq only -> C0, no halt (R9)
      step(1,1,0,0,0, 0,0,0, "R4");            // maxcoll queued behind, top still C0
      step(0,0,0,0,0, 1,0,0, "R5");            // pop -> 88
      step(0,0,0,0,0, 0,1,0, "R9");            // enable clears halt
      step(0,0,0,0,0, 1,0,0, "R6");            // empty again
      step(0,0,0,0,0, 1,0,0, "R5");            // pop on empty
      step(1,0,0,0,1, 0,0,0, "R7");            // fill four
      step(1,1,0,0,1, 0,0,0, "R7");
      step(1,1,0,0,0, 0,0,0, "R7");
      step(1,0,0,0,1, 0,0,0, "R7");
      step(1,1,0,0,0, 0,0,0, "R7");            // full: overflow mark on newest
      step(1,0,0,0,1, 1,0,0, "R8");            // pop + push on full
      for (int k = 0; k < 4; k++) step(0,0,0,0,0, 1,0,0, "R7");
      step(0,0,0,0,0, 0,1,0, "R9");
      step(1,0,1,0,0, 0,0,0, "R10");           // underrun
      step(0,0,0,0,0, 0,1,0, "R10");           // enable blocked
      step(1,0,0,0,1, 0,0,1, "R11");           // reset ignores event
      step(0,0,0,0,0, 0,1,0, "R9");            // enable now clears
      step(1,0,0,1,0, 0,1,0, "R12");           // jabber with enable
      step(1,0,0,0,1, 0,0,0, "R2");
      step(0,0,0,0,0, 0,0,1, "R11");
      step(0,0,0,0,0, 0,1,0, "R10");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule